// File: doc/BRIEF.md
# External bus strobe generator

This block produces the two external memory strobes of an 8-bit microcontroller whose machine cycle lasts twelve oscillator clocks. An address-latch strobe pulses twice per machine cycle so that outside logic can capture the low address byte. An active-low program-store read strobe fires twice per machine cycle while code is fetched from external memory. Both strobes drop pulses while the core makes an external data access, and both are parked at fixed levels in the two low-power modes.

Software can switch the latch strobe off through a one-bit control register. While it is switched off, the pin is released and only a weak pull-up holds it high. The core overrides that setting whenever the strobe is needed: during move-external and move-code instructions, in idle, in power-down, in emulation, and whenever code runs from external memory. The control register sits at bus address 0x8E. Its bit 0 is the disable, and it reads back with all other bits zero.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: After synchronous reset is released, the oscillator phase counts 0,1,…,11 and wraps to 0, advancing once per clock. In run mode with no external data access and the disable not in force, `latch_o` is 1 in phases 0, 1, 6 and 7 and 0 in every other phase.
- R2: While `ext_data_i` is 1 in run mode, the second latch pulse (phases 6 and 7) is suppressed and the first pulse (phases 0 and 1) is kept.
- R3: In run mode with `ext_code_i`=1 and `ext_data_i`=0, `psen_n_o` is 0 in phases 3, 4, 5, 9, 10 and 11 and 1 in the other phases. With `ext_code_i`=0, `psen_n_o` stays 1 in run mode.
- R4: In run mode with `ext_code_i`=1 and `ext_data_i`=1, `psen_n_o` stays 1 in all twelve phases.
- R5: A write with `ctrl_we_i`=1 and `ctrl_addr_i`=0x8E loads bit 0 of `ctrl_wdata_i` into the disable bit at the next clock. Writes to any other address leave the bit unchanged. `ctrl_rdata_o` always shows the disable bit in bit 0 and zero in bits 7..1.
- R6: When the disable bit is 1 and none of `ext_code_i`, `movx_i`, `idle_i`, `pdown_i` or `emul_i` is 1, `latch_oe_o`=0, `latch_wpu_o`=1 and `latch_o`=1. Otherwise `latch_oe_o`=1 and `latch_wpu_o`=0. The two enables are always complementary.
- R7: With the disable bit set, each of `movx_i`, `emul_i`, `idle_i`, `pdown_i` and `ext_code_i` alone restores the driven strobe with its normal waveform for the mode in force.
- R8: In idle (`idle_i`=1, `pdown_i`=0), `latch_o`=1 and `psen_n_o`=1 in every phase, with the latch pin driven.
- R9: In power-down (`pdown_i`=1, regardless of `idle_i`), `latch_o`=0 and `psen_n_o`=0 in every phase, with the latch pin driven.
- R10: Reset clears the phase to 0 and the disable bit to 0, including when reset is applied in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_code_i | input | 1 | Core is executing from external program memory |
| ext_data_i | input | 1 | External data memory access in the current machine cycle |
| movx_i | input | 1 | A move-external or move-code instruction is active |
| idle_i | input | 1 | Idle mode |
| pdown_i | input | 1 | Power-down mode |
| emul_i | input | 1 | Emulation mode |
| ctrl_we_i | input | 1 | Control-register write strobe |
| ctrl_addr_i | input | 8 | Control-register write address |
| ctrl_wdata_i | input | 8 | Control-register write data |
| ctrl_rdata_o | output | 8 | Control-register read-back value |
| latch_o | output | 1 | Address-latch strobe level |
| latch_oe_o | output | 1 | Drive enable for the latch strobe pin |
| latch_wpu_o | output | 1 | Weak pull-up enable for the latch strobe pin |
| psen_n_o | output | 1 | Active-low program-store read strobe |

## Verification
The strobe outputs are decoded without a register from the phase register and the current mode inputs. A change of `ext_data_i`, the mode flags or the disable bit therefore shows in the same cycle. The waveform moves one phase per clock edge. A control write reaches the disable bit, and `ctrl_rdata_o`, one edge after the write is presented. The bench drives inputs just after a falling edge and samples 1 ns later. It keeps its own phase count, cleared by reset and advanced on every rising edge, and compares each sample with the bit for that phase in twelve-bit expected masks. After a control write it waits for the next falling edge before reading the register back.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pwr_mode_t;

    typedef struct packed {
        logic ext_code;
        logic ext_data;
        logic movx;
        logic idle;
        logic pdown;
        logic emul;
    } core_state_t;

    typedef struct packed {
        logic level;
        logic oe;
        logic wpu;
    } pin_drive_t;

    // power-down outranks idle
    function automatic pwr_mode_t pick_mode(input logic idle, input logic pdown);
        if (pdown)     return MODE_PDOWN;
        else if (idle) return MODE_IDLE;
        else           return MODE_RUN;
    endfunction

    function automatic logic disable_overridden(input core_state_t st);
        return st.ext_code | st.movx | st.idle | st.pdown | st.emul;
    endfunction

endpackage

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
    parameter int CYCLE_LEN = 12,
    localparam int PH_W = $clog2(CYCLE_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(CYCLE_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)                phase_o <= '0;
        else if (phase_o == LAST) phase_o <= '0;
        else                    phase_o <= phase_o + 1'b1;
    end

    p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == LAST) |=> (phase_o == '0));
    p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_o != LAST) |=> (phase_o == $past(phase_o) + 1'b1));
    p_phase_range_r1: assert property (@(posedge clk) disable iff (rst)
        phase_o <= LAST);

endmodule

// File: rtl/xbs_ctrl_reg.sv
module xbs_ctrl_reg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CTRL_ADDR = 'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dis_o
);
    logic hit;
    assign hit = we_i && (addr_i == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (rst)      dis_o <= 1'b0;
        else if (hit) dis_o <= wdata_i[0];
    end

    assign rdata_o = {{(DATA_W-1){1'b0}}, dis_o};

    p_ctrl_load_r5: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> (dis_o == $past(wdata_i[0])));
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(we_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> $stable(dis_o));
    p_ctrl_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (dis_o == 1'b0));

endmodule

// File: rtl/xbs_strobe_decode.sv
module xbs_strobe_decode
    import xbs_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int LATCH_LEN = 2,
    parameter int PSEN_START = 3,
    localparam int PH_W = $clog2(CYCLE_LEN),
    localparam int HALF = CYCLE_LEN / 2
) (
    input  logic [PH_W-1:0] phase_i,
    input  core_state_t     st_i,
    input  logic            dis_i,
    output pin_drive_t      latch_o,
    output logic            psen_n_o
);
    logic            second_half;
    logic [PH_W-1:0] sub_phase;
    logic            latch_pulse;
    logic            psen_active;
    logic            disable_live;
    pwr_mode_t       mode;

    always_comb begin
        second_half  = (phase_i >= PH_W'(HALF));
        sub_phase    = second_half ? (phase_i - PH_W'(HALF)) : phase_i;
        latch_pulse  = (sub_phase < PH_W'(LATCH_LEN)) && !(second_half && st_i.ext_data);
        psen_active  = st_i.ext_code && !st_i.ext_data && (sub_phase >= PH_W'(PSEN_START));
        disable_live = dis_i && !disable_overridden(st_i);
        mode         = pick_mode(st_i.idle, st_i.pdown);

        latch_o  = '{level: 1'b1, oe: 1'b1, wpu: 1'b0};
        psen_n_o = 1'b1;
        unique case (mode)
            MODE_PDOWN: begin
                latch_o.level = 1'b0;
                psen_n_o      = 1'b0;
            end
            MODE_IDLE: begin
                latch_o.level = 1'b1;
                psen_n_o      = 1'b1;
            end
            default: begin
                psen_n_o = !psen_active;
                if (disable_live) latch_o = '{level: 1'b1, oe: 1'b0, wpu: 1'b1};
                else              latch_o.level = latch_pulse;
            end
        endcase
    end

endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
    import xbs_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CTRL_ADDR = 'h8E,
    localparam int PH_W = $clog2(CYCLE_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_code_i,
    input  logic              ext_data_i,
    input  logic              movx_i,
    input  logic              idle_i,
    input  logic              pdown_i,
    input  logic              emul_i,
    input  logic              ctrl_we_i,
    input  logic [ADDR_W-1:0] ctrl_addr_i,
    input  logic [DATA_W-1:0] ctrl_wdata_i,
    output logic [DATA_W-1:0] ctrl_rdata_o,
    output logic              latch_o,
    output logic              latch_oe_o,
    output logic              latch_wpu_o,
    output logic              psen_n_o
);
    logic [PH_W-1:0] phase;
    logic            dis;
    core_state_t     st;
    pin_drive_t      latch_drv;

    assign st = '{ext_code: ext_code_i, ext_data: ext_data_i, movx: movx_i,
                  idle: idle_i, pdown: pdown_i, emul: emul_i};

    xbs_phase_ctr #(.CYCLE_LEN(CYCLE_LEN)) u_phase (
        .clk(clk), .rst(rst), .phase_o(phase)
    );

    xbs_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk(clk), .rst(rst), .we_i(ctrl_we_i), .addr_i(ctrl_addr_i),
        .wdata_i(ctrl_wdata_i), .rdata_o(ctrl_rdata_o), .dis_o(dis)
    );

    xbs_strobe_decode #(.CYCLE_LEN(CYCLE_LEN)) u_dec (
        .phase_i(phase), .st_i(st), .dis_i(dis),
        .latch_o(latch_drv), .psen_n_o(psen_n_o)
    );

    assign latch_o     = latch_drv.level;
    assign latch_oe_o  = latch_drv.oe;
    assign latch_wpu_o = latch_drv.wpu;

    p_enables_excl_r6: assert property (@(posedge clk) disable iff (rst)
        latch_oe_o != latch_wpu_o);
    p_override_drives_r7: assert property (@(posedge clk) disable iff (rst)
        (movx_i || emul_i || idle_i || pdown_i || ext_code_i) |-> latch_oe_o);
    p_idle_levels_r8: assert property (@(posedge clk) disable iff (rst)
        (idle_i && !pdown_i) |-> (latch_o && psen_n_o));
    p_pdown_levels_r9: assert property (@(posedge clk) disable iff (rst)
        pdown_i |-> (!latch_o && !psen_n_o));
    p_psen_skip_r4: assert property (@(posedge clk) disable iff (rst)
        (ext_code_i && ext_data_i && !idle_i && !pdown_i) |-> psen_n_o);
    p_no_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        (!ext_code_i && !pdown_i) |-> psen_n_o);
    p_second_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (ext_data_i && !idle_i && !pdown_i && latch_oe_o && phase >= PH_W'(CYCLE_LEN / 2))
        |-> !latch_o);

endmodule

// File: tb/test_ext_bus_strobe_gen.sv
module test_ext_bus_strobe_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_code = 0, ext_data = 0, movx = 0, idle = 0, pdown = 0, emul = 0;
    logic       we = 0;
    logic [7:0] addr = 0, wdata = 0;
    logic [7:0] rdata;
    logic       latch, latch_oe, latch_wpu, psen_n;

    int total = 0;
    int bad = 0;
    int bph = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ext_bus_strobe_gen i_ext_bus_strobe_gen (
        .clk(clk), .rst(rst), .ext_code_i(ext_code), .ext_data_i(ext_data),
        .movx_i(movx), .idle_i(idle), .pdown_i(pdown), .emul_i(emul),
        .ctrl_we_i(we), .ctrl_addr_i(addr), .ctrl_wdata_i(wdata),
        .ctrl_rdata_o(rdata), .latch_o(latch), .latch_oe_o(latch_oe),
        .latch_wpu_o(latch_wpu), .psen_n_o(psen_n)
    );

    // independent phase model (R1): cleared by reset, one step per rising edge
    always @(posedge clk) begin
        if (rst) bph <= 0;
        else     bph <= (bph == 11) ? 0 : bph + 1;
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0; addr = 0; wdata = 0;
    endtask

    // {dis, ext_code, ext_data, movx, idle, pdown, emul, latch[11:0], psen_n[11:0], oe}
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {7'b0000000, 12'h0C3, 12'hFFF, 1'b1}, // R1 internal fetch
        {7'b0010000, 12'h003, 12'hFFF, 1'b1}, // R2 data access
        {7'b0100000, 12'h0C3, 12'h1C7, 1'b1}, // R3 external fetch
        {7'b0110000, 12'h003, 12'hFFF, 1'b1}, // R4 external fetch with data access
        {7'b0000100, 12'hFFF, 12'hFFF, 1'b1}, // R8 idle
        {7'b0000010, 12'h000, 12'h000, 1'b1}, // R9 power-down
        {7'b0000110, 12'h000, 12'h000, 1'b1}, // R9 power-down wins over idle
        {7'b1000000, 12'hFFF, 12'hFFF, 1'b0}, // R6 disabled
        {7'b1100000, 12'h0C3, 12'h1C7, 1'b1}, // R7 external code overrides
        {7'b1001000, 12'h0C3, 12'hFFF, 1'b1}, // R7 move instruction overrides
        {7'b1000001, 12'h0C3, 12'hFFF, 1'b1}, // R7 emulation overrides
        {7'b1000100, 12'hFFF, 12'hFFF, 1'b1}, // R7 idle overrides
        {7'b1000010, 12'h000, 12'h000, 1'b1}, // R7 power-down overrides
        {7'b1010000, 12'hFFF, 12'hFFF, 1'b0}  // R6 data access alone does not override
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
            4: return "R8"; 5, 6: return "R9"; 7, 13: return "R6";
            default: return "R7";
        endcase
    endfunction

    logic [11:0] seen_latch, seen_psen, seen_oe, seen_wpu;
    logic        cur_dis = 0;

    task automatic run_phases();
        seen_latch = 0; seen_psen = 0; seen_oe = 0; seen_wpu = 0;
        for (int k = 0; k < 12; k++) begin
            #1;
            seen_latch[bph] = latch;
            seen_psen[bph]  = psen_n;
            seen_oe[bph]    = latch_oe;
            seen_wpu[bph]   = latch_wpu;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R10 reset state
        #1;
        check("R10 readback after reset", {24'h0, rdata}, 32'h0);
        check("R10 phase 0 after reset", {31'h0, latch}, 32'h1);
        check("R1 psen idle after reset", {31'h0, psen_n}, 32'h1);

        // R5 register access
        ctrl_write(8'h8F, 8'h01);
        #1 check("R5 other address ignored", {24'h0, rdata}, 32'h0);
        ctrl_write(8'h8E, 8'hFF);
        #1 check("R5 write sets bit 0 only in readback", {24'h0, rdata}, 32'h01);
        ctrl_write(8'h0E, 8'h00);
        #1 check("R5 other address keeps bit", {24'h0, rdata}, 32'h01);
        ctrl_write(8'h8E, 8'hFE);
        #1 check("R5 write clears bit", {24'h0, rdata}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            e = VEC[v];
            if (e[31] != cur_dis) begin
                ctrl_write(8'h8E, {7'h0, e[31]});
                cur_dis = e[31];
            end
            @(negedge clk);
            {ext_code, ext_data, movx, idle, pdown, emul} = e[30:25];
            run_phases();
            check({vec_tag(v), " latch"}, {20'h0, seen_latch}, {20'h0, e[24:13]});
            check({vec_tag(v), " psen_n"}, {20'h0, seen_psen}, {20'h0, e[12:1]});
            check({vec_tag(v), " drive enable"}, {20'h0, seen_oe}, {20'h0, {12{e[0]}}});
            check({vec_tag(v), " weak pull-up"}, {20'h0, seen_wpu}, {20'h0, {12{~e[0]}}});
        end

        // R10 reset in the middle of operation with the disable set
        {ext_code, ext_data, movx, idle, pdown, emul} = 6'b0;
        repeat (5) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        #1;
        check("R10 disable cleared by reset", {24'h0, rdata}, 32'h0);
        check("R10 pin driven after reset", {31'h0, latch_oe}, 32'h1);
        check("R10 phase 0 latch high", {31'h0, latch}, 32'h1);
        @(negedge clk); #1;
        check("R1 phase 1 latch high", {31'h0, latch}, 32'h1);
        @(negedge clk); #1;
        check("R1 phase 2 latch low", {31'h0, latch}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule